// File: doc/BRIEF.md
# Page-Table Refill Controller

This block services a translation miss in hardware. When the lookup logic reports a miss, the controller forms the physical address of the matching page-table entry from a table base and the miss address, issues a single 32-bit read on a valid/ready request channel, and waits for the response. A good response is turned into a TLB entry and installed through a one-cycle write port into one of four refillable ways. The victim way comes from a round-robin counter. The faulting address is latched into a visible register.

An error response ends the attempt with a one-cycle failure pulse. In that case nothing is written and the round-robin state is unchanged. The table address is used as a physical address, with no nested translation. The controller takes a new miss only while idle.

Top module: `pte_refill_ctrl`

## Requirements
- R1: After reset, `miss_ready` is 1, `mem_req_valid`, `tlb_wr_en` and `refill_fail` are 0, and `fault_vaddr` is 0.
- R2: The request address is `(tbl_base | (miss_vaddr >> 10))` with bits 1:0 forced to 0. It uses the values present in the cycle the miss is accepted.
- R3: `mem_req_valid` rises in the cycle after a miss is accepted. It stays high, with `mem_req_addr` unchanged, until a cycle in which `mem_req_ready` is 1.
- R4: Victim ways follow a 2-bit counter that resets to 0 and is incremented before use. The first successful refill after reset writes way 1, and later ones write 2, 3, 0, 1 and so on.
- R5: The written entry index is `miss_vaddr[13:12]`. The written page number is `miss_vaddr` with bits 11:0 cleared.
- R6: The written frame is the fetched word with bits 11:0 cleared. The written attribute is fetched bits 3:0.
- R7: Fetched bits 5:4 select a ring r. The written ASID is `ring_asids[8r+7:8r]`, sampled in the write cycle.
- R8: A data response accepted without error gives exactly one cycle of `tlb_wr_en`, in the cycle after the response. `miss_ready` returns to 1 in the cycle after that.
- R9: `fault_vaddr` takes the accepted miss address at the end of the write cycle. It holds its value at all other times.
- R10: An error response gives one cycle of `refill_fail` in the cycle after the response. It causes no TLB write, leaves `fault_vaddr` unchanged, and does not advance the victim counter.
- R11: While a refill is in progress, `miss_ready` is 0 and `miss_valid`, `miss_vaddr` and `tbl_base` have no effect on the request or on the entry that is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Miss request |
| miss_ready | output | 1 | Controller idle, miss accepted |
| miss_vaddr | input | 32 | Virtual address that missed |
| tbl_base | input | 32 | Page-table base |
| ring_asids | input | 32 | One ASID byte per ring, ring 0 in the low byte |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Table entry address |
| mem_rsp_valid | input | 1 | Read response present |
| mem_rsp_err | input | 1 | Response carries an error |
| mem_rsp_data | input | 32 | Fetched table entry |
| tlb_wr_en | output | 1 | TLB write strobe, also the success pulse |
| tlb_wr_way | output | 2 | Victim way |
| tlb_wr_index | output | 2 | Entry index within the way |
| tlb_wr_vpn | output | 32 | Page number tag |
| tlb_wr_frame | output | 32 | Physical frame |
| tlb_wr_asid | output | 8 | Address-space tag |
| tlb_wr_attr | output | 4 | Page attribute |
| refill_fail | output | 1 | Refill aborted by a memory error |
| fault_vaddr | output | 32 | Last successfully refilled miss address |

## Verification
The bench uses the default parameters: four refillable ways, two index bits above a 4 KB page, and four rings of 8-bit ASIDs. With four ways the counter wraps after four successful refills, so the bench can show way 0 being reached and way 1 coming round again. The four ring bytes are all distinct, so a wrong ring selection shows up as a wrong ASID. An error refill placed between successes shows that the counter holds its value. Stalled requests, with a second miss driven during the stall, cover the hold and ignore rules.

// File: rtl/refill_pkg.sv
// Shared types for the page-table refill controller.
// Assumes: four states only; encoding carries no meaning outside the FSM.
package refill_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_REQ   = 2'd1,
        ST_WAIT  = 2'd2,
        ST_WRITE = 2'd3
    } refill_state_t;
endpackage

// File: rtl/refill_addr_gen.sv
// Forms the table entry address: base OR shifted miss address, word aligned.
// Assumes: the table address is physical; no carry between base and offset.
module refill_addr_gen #(
    parameter int ADDR_W     = 32,
    parameter int PTE_SHIFT  = 10,
    parameter int ALIGN_BITS = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] vaddr,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK =
        {{(ADDR_W-ALIGN_BITS){1'b1}}, {ALIGN_BITS{1'b0}}};

    // Combine and align in one level of logic.
    assign entry_addr = (base | (vaddr >> PTE_SHIFT)) & ALIGN_MASK;
endmodule

// File: rtl/refill_pte_decode.sv
// Splits a fetched table entry into frame, attribute and ring-selected ASID.
// Assumes: ring field sits at RING_LSB; one ASID byte per ring in ring_asids.
module refill_pte_decode #(
    parameter int DATA_W    = 32,
    parameter int PAGE_BITS = 12,
    parameter int ATTR_W    = 4,
    parameter int RING_W    = 2,
    parameter int RING_LSB  = 4,
    parameter int ASID_W    = 8
) (
    input  logic [DATA_W-1:0]                  pte,
    input  logic [(ASID_W<<RING_W)-1:0]        ring_asids,
    output logic [DATA_W-1:0]                  frame,
    output logic [ATTR_W-1:0]                  attr,
    output logic [ASID_W-1:0]                  asid
);
    localparam int NUM_RINGS = 1 << RING_W;
    localparam logic [DATA_W-1:0] PAGE_MASK =
        {{(DATA_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

    logic [ASID_W-1:0] asid_opts [NUM_RINGS];
    logic [RING_W-1:0] ring;

    // One ASID candidate per ring.
    for (genvar r = 0; r < NUM_RINGS; r++) begin : g_ring
        assign asid_opts[r] = ring_asids[r*ASID_W +: ASID_W];
    end

    // Field extraction and ring select.
    assign ring  = pte[RING_LSB +: RING_W];
    assign asid  = asid_opts[ring];
    assign frame = pte & PAGE_MASK;
    assign attr  = pte[ATTR_W-1:0];
endmodule

// File: rtl/refill_victim_ctr.sv
// Round-robin victim selector: the offered way is the counter plus one,
// and the counter moves to it when a refill commits.
// Assumes: advance is high for one cycle per successful refill.
module refill_victim_ctr #(
    parameter int WAY_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [WAY_W-1:0] next_way
);
    logic [WAY_W-1:0] cnt;

    assign next_way = cnt + WAY_W'(1);

    // Counter register, moved only by a committed refill.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt <= '0;
        else if (advance) cnt <= next_way;
    end

    p_ctr_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> $stable(next_way));
endmodule

// File: rtl/pte_refill_ctrl.sv
// Hardware page-table refill controller: accepts a miss, reads one table
// entry, and installs it into a round-robin refill way, or reports failure.
// Assumes: one outstanding read; responses arrive only after request accept.
module pte_refill_ctrl
    import refill_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int NUM_WAYS  = 4,
    parameter int IDX_W     = 2,
    parameter int PAGE_BITS = 12,
    parameter int PTE_SHIFT = 10,
    parameter int ASID_W    = 8,
    parameter int RING_W    = 2,
    parameter int RING_LSB  = 4,
    parameter int ATTR_W    = 4,
    localparam int WAY_W    = $clog2(NUM_WAYS),
    localparam int ASIDS_W  = ASID_W << RING_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_valid,
    output logic               miss_ready,
    input  logic [ADDR_W-1:0]  miss_vaddr,
    input  logic [ADDR_W-1:0]  tbl_base,
    input  logic [ASIDS_W-1:0] ring_asids,
    output logic               mem_req_valid,
    input  logic               mem_req_ready,
    output logic [ADDR_W-1:0]  mem_req_addr,
    input  logic               mem_rsp_valid,
    input  logic               mem_rsp_err,
    input  logic [ADDR_W-1:0]  mem_rsp_data,
    output logic               tlb_wr_en,
    output logic [WAY_W-1:0]   tlb_wr_way,
    output logic [IDX_W-1:0]   tlb_wr_index,
    output logic [ADDR_W-1:0]  tlb_wr_vpn,
    output logic [ADDR_W-1:0]  tlb_wr_frame,
    output logic [ASID_W-1:0]  tlb_wr_asid,
    output logic [ATTR_W-1:0]  tlb_wr_attr,
    output logic               refill_fail,
    output logic [ADDR_W-1:0]  fault_vaddr
);
    localparam logic [ADDR_W-1:0] PAGE_MASK =
        {{(ADDR_W-PAGE_BITS){1'b1}}, {PAGE_BITS{1'b0}}};

    refill_state_t     state;
    logic [ADDR_W-1:0] miss_q;
    logic [ADDR_W-1:0] req_addr_q;
    logic [ADDR_W-1:0] pte_q;
    logic [ADDR_W-1:0] fault_q;
    logic              fail_q;
    logic [ADDR_W-1:0] entry_addr;

    refill_addr_gen #(
        .ADDR_W(ADDR_W), .PTE_SHIFT(PTE_SHIFT), .ALIGN_BITS(2)
    ) u_addr (
        .base(tbl_base), .vaddr(miss_vaddr), .entry_addr(entry_addr)
    );

    refill_pte_decode #(
        .DATA_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ATTR_W(ATTR_W),
        .RING_W(RING_W), .RING_LSB(RING_LSB), .ASID_W(ASID_W)
    ) u_decode (
        .pte(pte_q), .ring_asids(ring_asids),
        .frame(tlb_wr_frame), .attr(tlb_wr_attr), .asid(tlb_wr_asid)
    );

    refill_victim_ctr #(.WAY_W(WAY_W)) u_victim (
        .clk(clk), .rst_n(rst_n),
        .advance(state == ST_WRITE), .next_way(tlb_wr_way)
    );

    // Sequencer: accept, request, wait for response, commit or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            miss_q     <= '0;
            req_addr_q <= '0;
            pte_q      <= '0;
            fault_q    <= '0;
            fail_q     <= 1'b0;
        end else begin
            fail_q <= 1'b0;
            unique case (state)
                ST_IDLE: if (miss_valid) begin
                    miss_q     <= miss_vaddr;
                    req_addr_q <= entry_addr;
                    state      <= ST_REQ;
                end
                ST_REQ: if (mem_req_ready) state <= ST_WAIT;
                ST_WAIT: if (mem_rsp_valid) begin
                    if (mem_rsp_err) begin
                        fail_q <= 1'b1;
                        state  <= ST_IDLE;
                    end else begin
                        pte_q  <= mem_rsp_data;
                        state  <= ST_WRITE;
                    end
                end
                ST_WRITE: begin
                    fault_q <= miss_q;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Port-side views of the state.
    assign miss_ready    = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_REQ);
    assign mem_req_addr  = req_addr_q;
    assign tlb_wr_en     = (state == ST_WRITE);
    assign tlb_wr_index  = miss_q[PAGE_BITS +: IDX_W];
    assign tlb_wr_vpn    = miss_q & PAGE_MASK;
    assign refill_fail   = fail_q;
    assign fault_vaddr   = fault_q;

    p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    p_wr_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_wr_en |=> !tlb_wr_en && miss_ready);
    p_fault_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tlb_wr_en |=> $stable(fault_vaddr));
    p_fail_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
        refill_fail |-> !tlb_wr_en && miss_ready && $stable(fault_vaddr));
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || tlb_wr_en) |-> !miss_ready);
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tlb_wr_en, refill_fail, mem_req_valid}));
endmodule

// File: tb/pte_refill_ctrl_bench.sv
module pte_refill_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        miss_valid = 1'b0;
    logic        miss_ready;
    logic [31:0] miss_vaddr = '0;
    logic [31:0] tbl_base = '0;
    logic [31:0] ring_asids = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic        mem_rsp_err = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        tlb_wr_en;
    logic [1:0]  tlb_wr_way;
    logic [1:0]  tlb_wr_index;
    logic [31:0] tlb_wr_vpn;
    logic [31:0] tlb_wr_frame;
    logic [7:0]  tlb_wr_asid;
    logic [3:0]  tlb_wr_attr;
    logic        refill_fail;
    logic [31:0] fault_vaddr;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic [1:0]  model_cnt = 2'd0;
    logic [31:0] model_fault = '0;

    always #5 clk = ~clk;

    pte_refill_ctrl u_pte_refill_ctrl (
        .clk(clk), .rst_n(rst_n),
        .miss_valid(miss_valid), .miss_ready(miss_ready),
        .miss_vaddr(miss_vaddr), .tbl_base(tbl_base), .ring_asids(ring_asids),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
        .mem_rsp_data(mem_rsp_data),
        .tlb_wr_en(tlb_wr_en), .tlb_wr_way(tlb_wr_way),
        .tlb_wr_index(tlb_wr_index), .tlb_wr_vpn(tlb_wr_vpn),
        .tlb_wr_frame(tlb_wr_frame), .tlb_wr_asid(tlb_wr_asid),
        .tlb_wr_attr(tlb_wr_attr), .refill_fail(refill_fail),
        .fault_vaddr(fault_vaddr)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    // One full refill; err selects the error path, stall delays the accept.
    task automatic run_refill(input logic [31:0] va, input logic [31:0] base,
                              input logic [31:0] pte, input logic [31:0] asids,
                              input bit err, input int stall);
        logic [31:0] exp_addr;
        logic [1:0]  ring;
        exp_addr = (base | (va >> 10)) & 32'hFFFF_FFFC;
        @(negedge clk);
        miss_valid = 1'b1; miss_vaddr = va; tbl_base = base; ring_asids = asids;
        @(negedge clk);
        check("R11", "miss_ready busy", {31'd0, miss_ready}, 32'd0);
        check("R3", "req valid", {31'd0, mem_req_valid}, 32'd1);
        check("R2", "req addr", mem_req_addr, exp_addr);
        // R11: second miss while busy must be ignored
        miss_vaddr = ~va; tbl_base = ~base;
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check("R3", "req held", {31'd0, mem_req_valid}, 32'd1);
            check("R3", "addr stable", mem_req_addr, exp_addr);
        end
        miss_valid = 1'b0; mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        mem_rsp_valid = 1'b1; mem_rsp_err = err; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_err = 1'b0;
        if (err) begin
            check("R10", "fail pulse", {31'd0, refill_fail}, 32'd1);
            check("R10", "no write", {31'd0, tlb_wr_en}, 32'd0);
            check("R10", "fault kept", fault_vaddr, model_fault);
        end else begin
            model_cnt = model_cnt + 2'd1;
            ring = pte[5:4];
            check("R8", "write strobe", {31'd0, tlb_wr_en}, 32'd1);
            check("R10", "no fail", {31'd0, refill_fail}, 32'd0);
            check("R4", "victim way", {30'd0, tlb_wr_way}, {30'd0, model_cnt});
            check("R5", "index", {30'd0, tlb_wr_index}, {30'd0, va[13:12]});
            check("R5", "vpn", tlb_wr_vpn, {va[31:12], 12'h000});
            check("R6", "frame", tlb_wr_frame, {pte[31:12], 12'h000});
            check("R6", "attr", {28'd0, tlb_wr_attr}, {28'd0, pte[3:0]});
            check("R7", "asid", {24'd0, tlb_wr_asid}, (asids >> (8 * ring)) & 32'hFF);
            check("R9", "fault before commit", fault_vaddr, model_fault);
            model_fault = va;
        end
        @(negedge clk);
        check("R8", "strobe one cycle", {31'd0, tlb_wr_en}, 32'd0);
        check("R10", "fail one cycle", {31'd0, refill_fail}, 32'd0);
        check("R8", "idle again", {31'd0, miss_ready}, 32'd1);
        check("R9", "fault vaddr", fault_vaddr, model_fault);
        check("R11", "no extra request", {31'd0, mem_req_valid}, 32'd0);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "miss_ready", {31'd0, miss_ready}, 32'd1);
        check("R1", "req valid", {31'd0, mem_req_valid}, 32'd0);
        check("R1", "wr_en", {31'd0, tlb_wr_en}, 32'd0);
        check("R1", "fail", {31'd0, refill_fail}, 32'd0);
        check("R1", "fault vaddr", fault_vaddr, 32'd0);
    endtask

    task automatic t_basic();   // R4 first refill is way 1, ring 0
        run_refill(32'h1234_5678, 32'hC000_0000, 32'h0ABC_D00B, 32'h4433_2211, 1'b0, 0);
    endtask

    task automatic t_rings();   // R7 rings 1..3, with stalls (R3, R11)
        run_refill(32'h0000_3FFF, 32'h8000_0003, 32'hFFFF_F01C, 32'hA1B2_C3D4, 1'b0, 2);
        run_refill(32'hFFFF_E123, 32'h0040_0000, 32'h1000_0027, 32'hA1B2_C3D4, 1'b0, 1);
        run_refill(32'h7654_1000, 32'h00F0_0000, 32'h5555_5539, 32'hA1B2_C3D4, 1'b0, 3);
    endtask

    task automatic t_error();   // R10 abort, then R4 counter not advanced
        run_refill(32'hDEAD_B000, 32'h1000_0000, 32'hFFFF_FFFF, 32'h0102_0304, 1'b1, 0);
        run_refill(32'h0BAD_F00D, 32'h2000_0000, 32'h3333_3012, 32'h0102_0304, 1'b0, 0);
    endtask

    task automatic t_wrap();    // R4 continues past wrap
        run_refill(32'h0000_2000, 32'h0000_0000, 32'h0000_1000, 32'h0102_0304, 1'b0, 0);
        run_refill(32'hF000_1FFF, 32'hFFFF_FFFF, 32'h8765_4326, 32'h0102_0304, 1'b0, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog all: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_rings();
        t_error();
        t_wrap();
        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule